// File: doc/BRIEF.md
# ARINC 429 Serial Word Receiver

The block takes the two digitized rails of an ARINC 429 line, which come from comparators outside it. It turns the return-to-null signalling back into a stream of bits and packs those bits into a 32-bit input register. A word ends only when the line has rested at null for a minimum gap. That gap is timed by counting rising edges of a separate gap clock, which is sampled in the system clock domain rather than used as a clock.

When a word closes, the block checks the bit count and, if parity checking is on, odd parity. It then presents the word in parallel, together with an error flag, in a one-cycle strobe. The presented word and flag stay on the outputs until the next word replaces them.

The parity-enable input is sampled at the moment the word closes. When parity checking is on, the top bit of the presented word carries the parity verdict and not the 32nd received bit.

Top module: `a429_word_rx`

## Requirements
- R1: While rst_n is low and after it rises, word_valid, word_data and word_err are all 0 until a word completes.
- R2: A bit is taken as 1 when rail_one is high and rail_zero low, and as 0 when rail_zero is high and rail_one low. The k-th received bit of a word (k = 1..32) lands at word_data[k-1], so the first bit is the LSB.
- R3: A null level separates consecutive bits. Null means both rails low or both rails high. Each active-to-null transition ends exactly one bit.
- R4: A word completes on the 16th gap_clk rising edge seen while the line stays null after its last bit. word_valid is then high for exactly one system clock cycle. No word completes while bits keep arriving with short nulls.
- R5: With par_en low and exactly 32 bits received, word_data equals the received bits unchanged, including bit 31, and word_err is 0.
- R6: With par_en high, odd parity is checked over the 32 stored bit positions. word_data[31] is 1 when the count of ones is even (parity failure) and 0 otherwise. word_err includes this failure.
- R7: If the word has a bit count other than 32, word_err is 1, whatever the state of par_en. Bit positions never received read 0. Bits after the 32nd are discarded.
- R8: Outside the completion strobe, word_data and word_err keep their last values.
- R9: Asserting rst_n low in the middle of a word discards the partial word. No completion follows from it, and the next word is received cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gap_clk | input | 1 | Gap timing clock, sampled as data |
| rail_one | input | 1 | Comparator output for a One level |
| rail_zero | input | 1 | Comparator output for a Zero level |
| par_en | input | 1 | High enables odd parity checking |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | 32 | Completed word, first bit at LSB |
| word_err | output | 1 | Bit count error, or parity error when enabled |

## Verification
The rails pass through two synchronizer flops and one bit latch. A bit is therefore recorded about three system cycles after the bench drives it, and each driven level is held four cycles so that it is seen reliably.

The completion strobe is due one cycle after the 16th gap-clock edge that the design detects. The bench counts its own gap-clock edges from the moment the final null begins and accepts a strobe only at edge 16 or 17. That tolerance covers the two-to-three cycle edge-detection delay; the gap clock runs eight system cycles per period.

Outputs are sampled on falling clock edges. The data and error flag are read in the same sampling slot as the strobe, and read again one slot later to confirm that the strobe has dropped.

// File: rtl/a429_word_rx.sv
module a429_word_rx #(
  parameter int WORD_BITS   = 32,
  parameter int GAP_EDGES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 gap_clk,
  input  logic                 rail_one,
  input  logic                 rail_zero,
  input  logic                 par_en,
  output logic                 word_valid,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_err
);
  localparam int CW = $clog2(WORD_BITS + 2);
  localparam int IW = $clog2(WORD_BITS);
  localparam int GW = $clog2(GAP_EDGES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_BITS);
  localparam logic [CW-1:0] CNT_SAT  = CW'(WORD_BITS + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_EDGES - 1);

  logic [SYNC_STAGES-1:0] one_sync, zero_sync;
  logic [SYNC_STAGES:0]   gclk_sync;
  logic                   bit_lat;
  logic [CW-1:0]          bit_cnt;
  logic [GW-1:0]          gap_cnt;
  logic [WORD_BITS-1:0]   shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      one_sync  <= '0;
      zero_sync <= '0;
      gclk_sync <= '0;
    end else begin
      one_sync  <= {one_sync[SYNC_STAGES-2:0], rail_one};
      zero_sync <= {zero_sync[SYNC_STAGES-2:0], rail_zero};
      gclk_sync <= {gclk_sync[SYNC_STAGES-1:0], gap_clk};
    end

  wire one_lvl  = one_sync[SYNC_STAGES-1];
  wire zero_lvl = zero_sync[SYNC_STAGES-1];
  wire mark     = one_lvl ^ zero_lvl;
  wire bit_set  = mark & ~bit_lat;
  wire gap_tick = gclk_sync[SYNC_STAGES-1] & ~gclk_sync[SYNC_STAGES];
  wire in_word  = bit_cnt != '0;
  wire word_end = in_word & ~mark & gap_tick & (gap_cnt == GAP_LAST);
  wire par_fail = ~^shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_lat    <= 1'b0;
      bit_cnt    <= '0;
      gap_cnt    <= '0;
      shreg      <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
      word_err   <= 1'b0;
    end else begin
      bit_lat    <= mark;
      word_valid <= word_end;
      if (word_end) begin
        bit_cnt   <= '0;
        gap_cnt   <= '0;
        shreg     <= '0;
        word_data <= par_en ? {par_fail, shreg[WORD_BITS-2:0]} : shreg;
        word_err  <= (bit_cnt != CNT_FULL) | (par_en & par_fail);
      end else begin
        if (mark)
          gap_cnt <= '0;
        else if (gap_tick && in_word)
          gap_cnt <= gap_cnt + 1'b1;
        if (bit_set) begin
          if (bit_cnt < CNT_FULL)
            shreg[bit_cnt[IW-1:0]] <= one_lvl;
          if (bit_cnt != CNT_SAT)
            bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R4
  AST_END_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> $past(gap_tick) && !$past(mark)); // R4
  AST_COUNT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && ($past(bit_cnt) != CNT_FULL) |-> word_err); // R7
  AST_PAR_OFF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !$past(par_en) && ($past(bit_cnt) == CNT_FULL) |-> !word_err); // R5
  AST_PAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && $past(par_en) |-> word_err == (word_data[WORD_BITS-1] | ($past(bit_cnt) != CNT_FULL))); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_data) && $stable(word_err)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_SAT); // R7
endmodule

// File: tb/a429_word_rx_bench.sv
module a429_word_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0, gap_clk = 1'b0;
  logic rail_one = 1'b0, rail_zero = 1'b0, par_en = 1'b0;
  logic word_valid, word_err;
  logic [31:0] word_data;
  int checks = 0, failures = 0, gcount = 0, pulses = 0;

  a429_word_rx u_a429_word_rx (.clk(clk), .rst_n(rst_n), .gap_clk(gap_clk),
    .rail_one(rail_one), .rail_zero(rail_zero), .par_en(par_en),
    .word_valid(word_valid), .word_data(word_data), .word_err(word_err));

  always #10 clk = ~clk;
  initial forever #80 gap_clk = ~gap_clk;
  always @(posedge gap_clk) gcount++;
  always @(negedge clk) if (word_valid) pulses++;

  // {par_en, both-high separator, bit count, data}
  localparam logic [39:0] VEC [0:7] = '{
    {1'b0, 1'b0, 6'd32, 32'hA5A5_1234},
    {1'b0, 1'b1, 6'd32, 32'hFFFF_FFFF},
    {1'b1, 1'b0, 6'd32, 32'h0000_0001},
    {1'b1, 1'b0, 6'd32, 32'h0000_0003},
    {1'b0, 1'b0, 6'd31, 32'h7FFF_FFFF},
    {1'b0, 1'b0, 6'd33, 32'h8000_0001},
    {1'b1, 1'b1, 6'd32, 32'h8000_0000},
    {1'b1, 1'b0, 6'd20, 32'h000F_FFFF}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic a, logic b, int n);
    rail_one = a; rail_zero = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(int n, logic [31:0] d, logic sep_hi, output int gstart);
    gstart = 0;
    for (int i = 0; i < n; i++) begin
      logic v;
      v = d[i % 32];
      drive(v, ~v, 4);
      if (i == n - 1) begin
        gstart = gcount;
        drive(1'b0, 1'b0, 4);
      end else drive(sep_hi, sep_hi, 4);
    end
  endtask

  task automatic run_word(string tag, int n, logic [31:0] d, logic p, logic sep_hi);
    int gs, p0, seen;
    logic [31:0] stored, exp_d;
    logic perr, exp_e;
    stored = (n < 32) ? (d & ((32'h1 << n) - 1)) : d;
    perr = ~^stored;
    exp_d = p ? {perr, stored[30:0]} : stored;
    exp_e = (n != 32) | (p & perr);
    par_en = p;
    p0 = pulses;
    @(negedge clk);
    send_bits(n, d, sep_hi, gs);
    check({tag, " R4 no early strobe"}, pulses, p0);
    seen = 0;
    for (int k = 0; k < 400 && !seen; k++) begin
      @(negedge clk);
      if (word_valid) begin
        seen = 1;
        check({tag, " R4 gap edges>=16"}, (gcount - gs) >= 16, 1);
        check({tag, " R4 gap edges<=17"}, (gcount - gs) <= 17, 1);
        check({tag, " R2 R5 R6 R7 data"}, word_data, exp_d);
        check({tag, " R5 R6 R7 err"}, word_err, exp_e);
        @(negedge clk);
        check({tag, " R4 one-cycle strobe"}, word_valid, 0);
      end
    end
    check({tag, " R4 strobe seen"}, seen, 1);
  endtask

  initial begin
    #3000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int gs;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset valid", word_valid, 0);
    check("R1 reset data", word_data, 0);
    check("R1 reset err", word_err, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset data", word_data, 0);
    for (int i = 0; i < 8; i++)
      run_word($sformatf("vec%0d R3", i), int'(VEC[i][37:32]), VEC[i][31:0], VEC[i][39], VEC[i][38]);
    held = word_data;
    drive(1'b1, 1'b1, 200);
    check("R8 data held", word_data, held);
    check("R8 err held", word_err, 1);
    send_bits(10, 32'h3FF, 1'b0, gs);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 reset clears data", word_data, 0);
    rst_n = 1'b1;
    gs = pulses;
    repeat (400) @(negedge clk);
    check("R9 no strobe from partial word", pulses, gs);
    run_word("R9 clean word after reset", 32, 32'h1357_9BDF, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule